// File: doc/BRIEF.md
# SMM Memory Window Access Controller

This block decides, for every memory access, where it should land. It covers three protected areas. The first is the 128 KB legacy window at 0x000A0000–0x000BFFFF. The second is a 128 KB alias of that same DRAM at 0xFEDA0000–0xFEDBFFFF. The third is a TSEG region carved just below a static top-of-low-memory address. Each access carries an address, a system-management-mode flag and a write flag. The block answers with one of three routes: DRAM, forward to the video/PCI space, or black-hole. For black-holed reads it also returns the read data.

Two configuration bytes set the policy. A window control byte holds the open, lock and global-enable bits. An extended control byte holds the high-enable bit and the TSEG enable and size code. Setting the lock bit closes the window and freezes both bytes until reset.

Accesses enter on a valid/ready request channel and leave on a valid/ready response channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. A response stays valid, with its route and data unchanged, until `rsp_ready` takes it. The decode uses the configuration bytes as they stand at the acceptance edge. A configuration write takes effect for requests accepted on later edges.

Top module: `smram_ctl`

## Requirements
- R1: The response appears one cycle after acceptance. `req_ready` equals `!rsp_valid || rsp_ready`. A response held by back-pressure keeps `rsp_route` and `rsp_rdata` unchanged.
- R2: Route codes are 2'b00 DRAM, 2'b01 video/PCI forward and 2'b10 black-hole. Code 2'b11 never appears. Addresses outside all three areas route to DRAM.
- R3: The config byte is selected by `cfg_sel`: 0 selects the window control byte, 1 selects the extended byte. Window control layout: bit 6 open, bit 4 lock, bit 3 global enable; bits 2:0 always read 3'b010; all other bits read 0. Extended layout: bit 7 high enable, bits 2:1 TSEG size code, bit 0 TSEG enable; all other bits read 0. `cfg_rdata` shows the selected byte combinationally.
- R4: A non-SMM access to the low window routes to DRAM when open and high enable are both set. Otherwise it is forwarded.
- R5: A non-SMM access to the high alias routes to DRAM when open and high enable are both set. Otherwise it is forwarded.
- R6: For an SMM access, the low window routes to DRAM when global enable is set and high enable is clear. The high alias routes to DRAM when global enable and high enable are both set. Every other SMM window access is forwarded.
- R7: A write that sets lock also clears open in the same write. After lock is set, writes to either byte change nothing until reset.
- R8: Reset returns the window control byte to 0x02 and the extended byte to 0x00, clears lock and empties the response register.
- R9: With TSEG enabled, size codes 00, 01 and 10 give 1 MB, 2 MB and 8 MB. Code 11, or TSEG disabled, gives no TSEG.
- R10: TSEG covers [top − size, top). SMM accesses there route to DRAM. Non-SMM accesses there are black-holed: reads return 0xFFFFFFFF and writes are dropped. Every other response carries zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Access address |
| req_smm | input | 1 | Access issued in system-management mode |
| req_write | input | 1 | Access is a write |
| tolm | input | ADDR_W | Static top-of-low-memory address |
| rsp_valid | output | 1 | Decision valid |
| rsp_ready | input | 1 | Decision consumed |
| rsp_route | output | 2 | Route code |
| rsp_rdata | output | DATA_W | Read data for black-holed reads |
| cfg_we | input | 1 | Config byte write strobe |
| cfg_sel | input | 1 | Config byte select |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Selected config byte |

## Verification
The bench builds the block with its default 32-bit address and data widths and drives `tolm` to 0x80000000. This keeps all three areas inside one address space: the high alias, each TSEG size just under the 2 GB line, and plain DRAM on both sides of every boundary. Every mix of open, lock, global enable and high enable is applied after a fresh reset. Each mix is exercised by SMM and non-SMM reads and writes while the response channel is throttled, so both back-pressure and TSEG edges are covered.

// File: rtl/smram_pkg.sv
package smram_pkg;
  typedef enum logic [1:0] {
    ROUTE_DRAM = 2'b00,
    ROUTE_FWD  = 2'b01,
    ROUTE_HOLE = 2'b10
  } route_e;

  // window control byte
  localparam int CTL_OPEN_BIT = 6;
  localparam int CTL_LOCK_BIT = 4;
  localparam int CTL_GEN_BIT  = 3;
  localparam logic [7:0] CTL_FIXED     = 8'h02;
  localparam logic [7:0] CTL_WMASK     = 8'h58;
  localparam logic [7:0] CTL_LOCK_MASK = 8'h00;
  localparam logic [7:0] CTL_DEFAULT   = 8'h02;

  // extended control byte
  localparam int EXT_HEN_BIT  = 7;
  localparam int EXT_SZ_LSB   = 1;
  localparam int EXT_TEN_BIT  = 0;
  localparam logic [7:0] EXT_WMASK     = 8'h87;
  localparam logic [7:0] EXT_LOCK_MASK = 8'h00;
  localparam logic [7:0] EXT_DEFAULT   = 8'h00;

  localparam int MB_SHIFT = 20;
endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       sel,
  input  logic [7:0] wdata,
  output logic [7:0] ctl_q,
  output logic [7:0] ext_q
);
  logic       locked;
  logic [7:0] ctl_mask, ext_mask;
  logic [7:0] ctl_nxt, ext_nxt;

  assign locked   = ctl_q[CTL_LOCK_BIT];
  assign ctl_mask = locked ? CTL_LOCK_MASK : CTL_WMASK;
  assign ext_mask = locked ? EXT_LOCK_MASK : EXT_WMASK;

  always_comb begin
    ctl_nxt = (ctl_q & ~ctl_mask) | (wdata & ctl_mask);
    ctl_nxt = (ctl_nxt & ~8'h07) | CTL_FIXED;
    if (ctl_nxt[CTL_LOCK_BIT]) ctl_nxt[CTL_OPEN_BIT] = 1'b0;
    ext_nxt = (ext_q & ~ext_mask) | (wdata & ext_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTL_DEFAULT;
      ext_q <= EXT_DEFAULT;
    end else if (we) begin
      if (!sel) ctl_q <= ctl_nxt;
      else      ext_q <= ext_nxt;
    end
  end
endmodule

// File: rtl/smram_tseg_win.sv
module smram_tseg_win
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] tolm,
  input  logic              tseg_en,
  input  logic [1:0]        size_code,
  output logic              hit
);
  logic [ADDR_W-1:0] size_b, base;

  always_comb begin
    size_b = '0;
    if (tseg_en) begin
      unique case (size_code)
        2'b00:   size_b = ADDR_W'(1) << MB_SHIFT;
        2'b01:   size_b = ADDR_W'(1) << (MB_SHIFT + 1);
        2'b10:   size_b = ADDR_W'(1) << (MB_SHIFT + 3);
        default: size_b = '0;
      endcase
    end
  end

  assign base = tolm - size_b;
  assign hit  = (size_b != '0) && (addr >= base) && (addr < tolm);
endmodule

// File: rtl/smram_route_dec.sv
module smram_route_dec
  import smram_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [ADDR_W-1:0] WIN_BYTES = 32'h0002_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm,
  input  logic              open,
  input  logic              gen,
  input  logic              hen,
  input  logic              tseg_hit,
  output route_e            route
);
  localparam logic [ADDR_W-1:0] LOW_END  = LOW_BASE + WIN_BYTES;
  localparam logic [ADDR_W-1:0] HIGH_END = HIGH_BASE + WIN_BYTES;

  logic in_low, in_high, low_dram, high_dram;

  assign in_low  = (addr >= LOW_BASE)  && (addr < LOW_END);
  assign in_high = (addr >= HIGH_BASE) && (addr < HIGH_END);

  assign low_dram  = smm ? (gen && !hen) : (open && hen);
  assign high_dram = smm ? (gen && hen)  : (open && hen);

  always_comb begin
    if (in_low)        route = low_dram  ? ROUTE_DRAM : ROUTE_FWD;
    else if (in_high)  route = high_dram ? ROUTE_DRAM : ROUTE_FWD;
    else if (tseg_hit) route = smm ? ROUTE_DRAM : ROUTE_HOLE;
    else               route = ROUTE_DRAM;
  end
endmodule

// File: rtl/smram_ctl.sv
module smram_ctl
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_smm,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] tolm,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_route,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata
);
  logic [7:0]  ctl_q, ext_q;
  logic        tseg_hit, accept;
  route_e      route_d;

  smram_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .ctl_q(ctl_q), .ext_q(ext_q)
  );

  smram_tseg_win #(.ADDR_W(ADDR_W)) u_tseg (
    .addr(req_addr), .tolm(tolm),
    .tseg_en(ext_q[EXT_TEN_BIT]),
    .size_code(ext_q[EXT_SZ_LSB +: 2]),
    .hit(tseg_hit)
  );

  smram_route_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .smm(req_smm),
    .open(ctl_q[CTL_OPEN_BIT]), .gen(ctl_q[CTL_GEN_BIT]),
    .hen(ext_q[EXT_HEN_BIT]), .tseg_hit(tseg_hit),
    .route(route_d)
  );

  assign cfg_rdata = cfg_sel ? ext_q : ctl_q;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_route <= ROUTE_DRAM;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_route <= route_d;
        rsp_rdata <= (route_d == ROUTE_HOLE && !req_write) ? '1 : '0;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/smram_ctl_chk.sv
module smram_ctl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_route,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [7:0]        ctl_q,
  input logic [7:0]        ext_q
);
  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_route) && $stable(rsp_rdata));

  // R2
  route_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_route != 2'b11);

  // R7
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4] |=> ctl_q[4] && $stable(ctl_q) && $stable(ext_q));

  // R7
  lock_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4] |-> !ctl_q[6]);

  // R10
  quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_route != 2'b10 |-> rsp_rdata == '0);
endmodule

bind smram_ctl smram_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_route(rsp_route), .rsp_rdata(rsp_rdata), .ctl_q(ctl_q), .ext_q(ext_q)
);

// File: tb/tb_smram_ctl.sv
module tb_smram_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TOP = 32'h8000_0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_smm = 0, req_write = 0, rsp_ready = 1;
  logic [31:0] req_addr = 0;
  logic req_ready, rsp_valid;
  logic [1:0] rsp_route;
  logic [31:0] rsp_rdata;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] m_ctl = 8'h02, m_ext = 8'h00;
  logic [1:0]  q_route[$];
  logic [31:0] q_data[$];
  string       q_tag[$];

  smram_ctl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_smm(req_smm), .req_write(req_write), .tolm(TOP),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_route(rsp_route),
    .rsp_rdata(rsp_rdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // throttled consumer
  always @(negedge clk) begin
    cyc <= cyc + 1;
    rsp_ready <= (cyc % 7 != 3) && (cyc % 11 != 5);
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each handshake against the scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q_route.size() == 0) check(0, "R1 unexpected response", 32'(rsp_route), 0);
      else begin
        logic [1:0] er; logic [31:0] ed; string t;
        er = q_route.pop_front(); ed = q_data.pop_front(); t = q_tag.pop_front();
        check(rsp_route == er, t, 32'(rsp_route), 32'(er));
        check(rsp_rdata == ed, {t, " data R10"}, rsp_rdata, ed);
      end
    end
  end

  function automatic logic [31:0] tseg_size();
    if (!m_ext[0]) return 0;
    case (m_ext[2:1])
      2'b00: return 32'h0010_0000;
      2'b01: return 32'h0020_0000;
      2'b10: return 32'h0080_0000;
      default: return 0;
    endcase
  endfunction

  function automatic logic [1:0] model(input logic [31:0] a, input bit smm);
    bit op, ge, he; logic [31:0] sz;
    op = m_ctl[6]; ge = m_ctl[3]; he = m_ext[7]; sz = tseg_size();
    if (a >= 32'h000A_0000 && a < 32'h000C_0000) return smm ? ((ge && !he) ? 2'b00 : 2'b01) : ((op && he) ? 2'b00 : 2'b01);
    if (a >= 32'hFEDA_0000 && a < 32'hFEDC_0000) return smm ? ((ge && he) ? 2'b00 : 2'b01) : ((op && he) ? 2'b00 : 2'b01);
    if (sz != 0 && a >= TOP - sz && a < TOP) return smm ? 2'b00 : 2'b10;
    return 2'b00;
  endfunction

  task automatic send(input logic [31:0] a, input bit smm, input bit wr, input string tag);
    logic [1:0] r;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_smm = smm; req_write = wr;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    r = model(a, smm);
    q_route.push_back(r);
    q_data.push_back((r == 2'b10 && !wr) ? 32'hFFFF_FFFF : 32'h0);
    q_tag.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while (q_route.size() != 0 && guard < 100) begin @(negedge clk); guard++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic cfg_write(input bit sel, input logic [7:0] d);
    logic [7:0] nv;
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (!m_ctl[4]) begin
      if (!sel) begin
        nv = (d & 8'h58) | 8'h02;
        if (nv[4]) nv[6] = 0;
        m_ctl = nv;
      end else m_ext = d & 8'h87;
    end
  endtask

  task automatic cfg_check(input bit sel, input string tag);
    logic [7:0] e;
    @(negedge clk);
    cfg_sel = sel; #1;
    e = sel ? m_ext : m_ctl;
    check(cfg_rdata == e, tag, 32'(cfg_rdata), 32'(e));
  endtask

  task automatic do_reset();
    drain();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_ctl = 8'h02; m_ext = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(rsp_valid == 0, "R8 reset rsp_valid", 32'(rsp_valid), 0);
    cfg_check(0, "R8 reset ctl byte");
    cfg_check(1, "R8 reset ext byte");
    check(req_ready == 1, "R1 ready after reset", 32'(req_ready), 1);

    // R3 layout: every writable bit, fixed bits, zero bits
    cfg_write(1, 8'hFF); cfg_check(1, "R3 ext mask");
    cfg_write(0, 8'hAD); cfg_check(0, "R3 ctl mask");
    cfg_write(1, 8'h00); cfg_write(0, 8'h00); cfg_check(0, "R3 ctl clear");

    // R4 R5 R6 R7: every mix of open/lock/global/high, both modes
    for (int c = 0; c < 16; c++) begin
      bit op, lk, ge, he;
      op = c[0]; lk = c[1]; ge = c[2]; he = c[3];
      do_reset();
      cfg_write(1, {he, 6'b0, 1'b1});
      cfg_write(0, {1'b0, op, 1'b0, lk, ge, 3'b000});
      cfg_check(0, "R7 lock closes open");
      for (int s = 0; s < 2; s++) begin
        send(32'h000A_0000, s[0], 0, "R4 R6 low base");
        send(32'h000B_FFFC, s[0], 1, "R4 R6 low top");
        send(32'hFEDA_0000, s[0], 0, "R5 R6 high base");
        send(32'hFEDB_FFF0, s[0], 1, "R5 R6 high top");
        send(32'h7FF0_0000, s[0], 0, "R10 tseg read");
        send(32'h7FFF_FFFC, s[0], 1, "R10 tseg write");
        send(32'h000C_0000, s[0], 0, "R2 past low window");
        send(32'hFEDC_0000, s[0], 0, "R2 past high window");
      end
      if (lk) begin
        cfg_write(0, 8'h48); cfg_check(0, "R7 locked ctl write ignored");
        cfg_write(1, 8'h83); cfg_check(1, "R7 locked ext write ignored");
        send(32'h000A_0100, 0, 0, "R7 locked low decode");
      end
    end

    // R9 R10 sizes and boundaries
    do_reset();
    for (int code = 0; code < 5; code++) begin
      logic [31:0] sz;
      cfg_write(1, code == 4 ? 8'h04 : {5'b0, code[1:0], 1'b1});
      sz = tseg_size();
      if (sz == 0) sz = 32'h0010_0000;
      send(TOP - sz - 4, 0, 0, "R9 below tseg base");
      send(TOP - sz,     0, 0, "R9 at tseg base");
      send(TOP - 4,      0, 0, "R9 tseg last word");
      send(TOP,          0, 0, "R9 at top");
      send(TOP - sz,     1, 1, "R10 smm tseg write");
      send(TOP - 32'h0080_0000, 0, 0, "R9 8MB base");
    end

    // R1 back-to-back burst under back-pressure
    for (int k = 0; k < 20; k++) send(32'h7FFF_0000 + 32'(k*4), k[0], k[1], "R1 burst");
    drain();
    check(q_route.size() == 0, "R1 all responses delivered", 32'(q_route.size()), 0);

    // R8 reset unlocks
    cfg_write(0, 8'h10);
    do_reset();
    cfg_check(0, "R8 unlocked after reset");
    cfg_write(0, 8'h48); cfg_check(0, "R8 write after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule